// File: doc/BRIEF.md
# USB Endpoint Buffer Manager

This block connects a USB packet engine to a shared endpoint buffer RAM. For every decoded token it checks the function address against the address programmed for the device and drops tokens meant for other devices. It then picks the descriptor for the addressed endpoint and direction and moves the data bytes of the packet into or out of that endpoint's region of the RAM.

Each endpoint has a six-byte descriptor. The descriptor holds an enable bit, a type field, the buffer base address, the size of each buffer half, the byte counts of the halves, and status bits. These status bits are a full flag for each half, the active half, and a sticky overflow bit. A processor-side port reads and writes the descriptors one byte at a time. The block itself updates the status bits and the byte count when a packet completes. The processor is free to divide the buffer space (1832 bytes by default) among the endpoints. With double buffering, the packet engine can work on one half while the processor services the other.

Top module: `usb_ep_bufmgr`

## Requirements
- R1: A token is ignored unless both of the following hold. Its 7-bit function address must equal bits 6:0 of byte 0 of descriptor slot 15. Its endpoint number must be below 8. An ignored token gives no ack, no NAK and no RAM access.
- R2: The descriptor is chosen as follows. Endpoint 0 uses slot 0 in both directions. IN endpoint n (1..7) uses slot n. OUT endpoint n uses slot n+7.
- R3: The processor port holds slots 0..15, each with bytes 0..5, and every byte reads back what was last written. Bytes 6 and 7 always read 0. The byte layout is: 0 control, 1 base bits 7:0, 2 base bits 10:8, 3 half size, 4 count of half 0, 5 count of half 1. The control byte bits are: 7 enable, 6 double, 5 overflow, 4 active half, 3 full flag of half 1, 2 full flag of half 0, 1:0 type.
- R4: A token for a disabled endpoint gives a NAK pulse in the cycle after the token. An accepted token gives an ack pulse in that cycle.
- R5: On OUT, data byte k of the packet is written to RAM address base + (active half x half size) + k.
- R6: OUT bytes beyond the half size are dropped, and on completion the overflow bit is set. The stored byte count then equals the half size.
- R7: At the end of an OUT packet, the byte count is written into that half's count byte and the half's full flag is set. When double buffering is on, the active half toggles.
- R8: An OUT token to a half whose full flag is set gets a NAK, and the data that follows writes nothing.
- R9: An accepted IN token reports the half's byte count on tx_len. Each tx_req then returns the next byte one cycle later, and tx_last marks the final byte.
- R10: An IN token to a half whose full flag is clear gets a NAK. After the last IN byte, the half's full flag is cleared and, with double buffering, the active half toggles.
- R11: An IN token to a full half with count 0 is acked with tx_len 0. Its full flag is cleared at once and no byte is sent.
- R12: With the double bit clear, half 0 is always used and the active-half bit is never changed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Processor byte write strobe |
| cfg_idx | input | 4 | Descriptor slot select |
| cfg_byte | input | 3 | Byte select within slot |
| cfg_wdata | input | 8 | Processor write data |
| cfg_rdata | output | 8 | Processor read data (combinational) |
| tok_valid | input | 1 | Decoded token strobe |
| tok_addr | input | 7 | Token function address |
| tok_ep | input | 4 | Token endpoint number |
| tok_in | input | 1 | Token direction, 1 = IN |
| resp_ack | output | 1 | Token accepted pulse |
| resp_nak | output | 1 | Token refused pulse |
| rx_valid | input | 1 | OUT data byte strobe |
| rx_data | input | 8 | OUT data byte |
| rx_end | input | 1 | OUT packet complete |
| tx_req | input | 1 | Request next IN byte |
| tx_len | output | 8 | Byte count of accepted IN packet |
| tx_valid | output | 1 | IN byte valid |
| tx_data | output | 8 | IN byte |
| tx_last | output | 1 | Final IN byte marker |
| ram_we | output | 1 | Buffer RAM write enable |
| ram_re | output | 1 | Buffer RAM read enable |
| ram_addr | output | 11 | Buffer RAM address |
| ram_wdata | output | 8 | Buffer RAM write data |
| ram_rdata | input | 8 | Buffer RAM read data, one cycle after ram_re |

## Verification
All 128 function addresses are swept against a disabled endpoint, so only the programmed address can produce a NAK. Every endpoint number is then tried with each direction, which shows that each one reaches its own descriptor slot. OUT packets with a different length and base on each endpoint separate the address formula from the count write-back. An oversized packet, and a second packet sent to a full half, check truncation and refusal. IN packets on single and double buffered endpoints, plus a zero-length IN packet, show the half toggling and the full-flag clearing. Reading an IN on endpoint 0 after an OUT on it shows that the control endpoint uses one slot for both directions.

// File: rtl/ebm_pkg.sv
package ebm_pkg;
   localparam int DESC_BYTES = 6;
   // descriptor byte positions
   localparam int B_CTL     = 0;
   localparam int B_BASE_LO = 1;
   localparam int B_BASE_HI = 2;
   localparam int B_SIZE    = 3;
   localparam int B_CNT0    = 4;
   // control byte bits
   localparam int C_EN    = 7;
   localparam int C_DBL   = 6;
   localparam int C_OVF   = 5;
   localparam int C_HALF  = 4;
   localparam int C_FULL0 = 2;

   typedef enum logic [1:0] {XS_IDLE, XS_OUT, XS_IN} xstate_e;
endpackage

// File: rtl/ebm_desc_file.sv
module ebm_desc_file
   import ebm_pkg::*;
#(
   parameter int NDESC = 15,
   parameter int IW    = 4,
   parameter int AW    = 11
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          cpu_we,
   input  logic [IW-1:0] cpu_idx,
   input  logic [2:0]    cpu_byte,
   input  logic [7:0]    cpu_wdata,
   output logic [7:0]    cpu_rdata,
   input  logic [IW-1:0] lk_idx,
   output logic [7:0]    lk_ctl,
   output logic [AW-1:0] lk_base,
   output logic [7:0]    lk_size,
   output logic [7:0]    lk_cnt0,
   output logic [7:0]    lk_cnt1,
   output logic [6:0]    dev_addr,
   input  logic          wb_en,
   input  logic [IW-1:0] wb_idx,
   input  logic [7:0]    wb_ctl,
   input  logic          wb_cnt_we,
   input  logic          wb_cnt_half,
   input  logic [7:0]    wb_cnt
);
   localparam int SLOTS = 2**IW;

   logic [7:0] mem [SLOTS][DESC_BYTES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int s = 0; s < SLOTS; s++)
            for (int b = 0; b < DESC_BYTES; b++)
               mem[s][b] <= '0;
      end else begin
         if (cpu_we && (cpu_byte < 3'(DESC_BYTES)))
            mem[cpu_idx][cpu_byte] <= cpu_wdata;
         if (wb_en) begin
            mem[wb_idx][B_CTL] <= wb_ctl;
            if (wb_cnt_we)
               mem[wb_idx][B_CNT0 + int'(wb_cnt_half)] <= wb_cnt;
         end
      end
   end

   assign cpu_rdata = (cpu_byte < 3'(DESC_BYTES)) ? mem[cpu_idx][cpu_byte] : 8'h00;
   assign lk_ctl    = mem[lk_idx][B_CTL];
   assign lk_base   = {mem[lk_idx][B_BASE_HI][AW-9:0], mem[lk_idx][B_BASE_LO]};
   assign lk_size   = mem[lk_idx][B_SIZE];
   assign lk_cnt0   = mem[lk_idx][B_CNT0];
   assign lk_cnt1   = mem[lk_idx][B_CNT0+1];
   assign dev_addr  = mem[NDESC][B_CTL][6:0];

   // R3
   cpu_wr_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_we && !wb_en && cpu_byte < 3'(DESC_BYTES)) ##1
      (cpu_idx == $past(cpu_idx) && cpu_byte == $past(cpu_byte))
      |-> cpu_rdata == $past(cpu_wdata));
endmodule

// File: rtl/ebm_tok_decode.sv
module ebm_tok_decode #(
   parameter int NUM_EP = 8,
   parameter int IW     = 4
) (
   input  logic [6:0]    tok_addr,
   input  logic [3:0]    tok_ep,
   input  logic          tok_in,
   input  logic [6:0]    dev_addr,
   output logic          hit,
   output logic [IW-1:0] idx
);
   logic [4:0] out_slot;

   assign out_slot = {1'b0, tok_ep} + 5'(NUM_EP - 1);
   assign hit = (tok_addr == dev_addr) && ({1'b0, tok_ep} < 5'(NUM_EP));

   always_comb begin
      if (tok_ep == 4'd0)  idx = '0;
      else if (tok_in)     idx = IW'(tok_ep);
      else                 idx = IW'(out_slot);
   end
endmodule

// File: rtl/ebm_xfer.sv
module ebm_xfer
   import ebm_pkg::*;
#(
   parameter int IW     = 4,
   parameter int AW     = 11,
   parameter bit DBL_EN = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          tok_valid,
   input  logic          tok_hit,
   input  logic          tok_in,
   input  logic [IW-1:0] tok_idx,
   output logic [IW-1:0] lk_idx,
   input  logic [7:0]    lk_ctl,
   input  logic [AW-1:0] lk_base,
   input  logic [7:0]    lk_size,
   input  logic [7:0]    lk_cnt0,
   input  logic [7:0]    lk_cnt1,
   output logic          resp_ack,
   output logic          resp_nak,
   input  logic          rx_valid,
   input  logic [7:0]    rx_data,
   input  logic          rx_end,
   input  logic          tx_req,
   output logic [7:0]    tx_len,
   output logic          tx_valid,
   output logic [7:0]    tx_data,
   output logic          tx_last,
   output logic          ram_we,
   output logic          ram_re,
   output logic [AW-1:0] ram_addr,
   output logic [7:0]    ram_wdata,
   input  logic [7:0]    ram_rdata,
   output logic          wb_en,
   output logic [IW-1:0] wb_idx,
   output logic [7:0]    wb_ctl,
   output logic          wb_cnt_we,
   output logic          wb_cnt_half,
   output logic [7:0]    wb_cnt
);
   xstate_e       state;
   logic [IW-1:0] cur_idx;
   logic          cur_half;
   logic [AW-1:0] cur_base;
   logic [7:0]    cur_size, cur_cnt, ptr;
   logic          ovf_r;

   logic dbl_sel, half_now, full_now, start, acc, nak, zlp;
   logic out_wr, in_rd, in_last, out_done;
   logic [7:0] cnt_now;

   generate
      if (DBL_EN) begin : g_dbl
         assign dbl_sel = lk_ctl[C_DBL];
      end else begin : g_sgl
         assign dbl_sel = 1'b0;
      end
   endgenerate

   assign lk_idx   = (state == XS_IDLE) ? tok_idx : cur_idx;
   assign half_now = dbl_sel & lk_ctl[C_HALF];
   assign full_now = lk_ctl[C_FULL0 + int'(half_now)];
   assign cnt_now  = half_now ? lk_cnt1 : lk_cnt0;

   assign start = (state == XS_IDLE) && tok_valid && tok_hit;
   assign acc   = start && lk_ctl[C_EN] && (tok_in ? full_now : !full_now);
   assign nak   = start && !acc;
   assign zlp   = acc && tok_in && (cnt_now == 8'd0);

   assign out_wr   = (state == XS_OUT) && rx_valid && (ptr < cur_size);
   assign out_done = (state == XS_OUT) && rx_end;
   assign in_rd    = (state == XS_IN) && tx_req;
   assign in_last  = in_rd && ((ptr + 8'd1) == cur_cnt);

   // descriptor write-back on completion
   assign wb_en       = zlp | out_done | in_last;
   assign wb_idx      = lk_idx;
   assign wb_cnt_half = zlp ? half_now : cur_half;
   assign wb_cnt_we   = out_done;
   assign wb_cnt      = ptr;

   always_comb begin
      wb_ctl = lk_ctl;
      if (out_done) begin
         wb_ctl[C_FULL0 + int'(wb_cnt_half)] = 1'b1;
         if (ovf_r) wb_ctl[C_OVF] = 1'b1;
      end else begin
         wb_ctl[C_FULL0 + int'(wb_cnt_half)] = 1'b0;
      end
      if (dbl_sel) wb_ctl[C_HALF] = ~wb_cnt_half;
   end

   assign ram_addr  = cur_base
                    + (cur_half ? {{(AW-8){1'b0}}, cur_size} : {AW{1'b0}})
                    + {{(AW-8){1'b0}}, ptr};
   assign ram_we    = out_wr;
   assign ram_wdata = rx_data;
   assign ram_re    = in_rd;
   assign tx_data   = ram_rdata;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= XS_IDLE;
         cur_idx  <= '0;
         cur_half <= 1'b0;
         cur_base <= '0;
         cur_size <= '0;
         cur_cnt  <= '0;
         ptr      <= '0;
         ovf_r    <= 1'b0;
         resp_ack <= 1'b0;
         resp_nak <= 1'b0;
         tx_len   <= '0;
         tx_valid <= 1'b0;
         tx_last  <= 1'b0;
      end else begin
         resp_ack <= acc;
         resp_nak <= nak;
         tx_valid <= in_rd;
         tx_last  <= in_last;
         if (acc && tok_in) tx_len <= cnt_now;
         unique case (state)
            XS_IDLE: begin
               if (acc && !zlp) begin
                  state    <= tok_in ? XS_IN : XS_OUT;
                  cur_idx  <= tok_idx;
                  cur_half <= half_now;
                  cur_base <= lk_base;
                  cur_size <= lk_size;
                  cur_cnt  <= cnt_now;
                  ptr      <= '0;
                  ovf_r    <= 1'b0;
               end
            end
            XS_OUT: begin
               if (out_wr) ptr <= ptr + 8'd1;
               if (rx_valid && !out_wr) ovf_r <= 1'b1;
               if (rx_end) state <= XS_IDLE;
            end
            XS_IN: begin
               if (in_rd) ptr <= ptr + 8'd1;
               if (in_last) state <= XS_IDLE;
            end
            default: state <= XS_IDLE;
         endcase
      end
   end

   // R4
   resp_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({resp_ack, resp_nak}));
   // R4
   resp_after_tok_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (resp_ack || resp_nak) |-> $past(tok_valid));
   // R9
   tx_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tx_valid |-> $past(tx_req));
   // R5
   ram_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(ram_we && ram_re));
   // R8
   no_write_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ram_we |-> !$past(resp_nak));
endmodule

// File: rtl/usb_ep_bufmgr.sv
module usb_ep_bufmgr #(
   parameter int NUM_EP    = 8,
   parameter int AW        = 11,
   parameter int BUF_BYTES = 1832,
   parameter bit DBL_EN    = 1'b1,
   localparam int NDESC    = 2*NUM_EP - 1,
   localparam int IW       = $clog2(NDESC + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          cfg_we,
   input  logic [IW-1:0] cfg_idx,
   input  logic [2:0]    cfg_byte,
   input  logic [7:0]    cfg_wdata,
   output logic [7:0]    cfg_rdata,
   input  logic          tok_valid,
   input  logic [6:0]    tok_addr,
   input  logic [3:0]    tok_ep,
   input  logic          tok_in,
   output logic          resp_ack,
   output logic          resp_nak,
   input  logic          rx_valid,
   input  logic [7:0]    rx_data,
   input  logic          rx_end,
   input  logic          tx_req,
   output logic [7:0]    tx_len,
   output logic          tx_valid,
   output logic [7:0]    tx_data,
   output logic          tx_last,
   output logic          ram_we,
   output logic          ram_re,
   output logic [AW-1:0] ram_addr,
   output logic [7:0]    ram_wdata,
   input  logic [7:0]    ram_rdata
);
   generate
      if (NUM_EP < 2 || NUM_EP > 16) begin : g_bad_ep
         $error("NUM_EP must lie in 2..16");
      end
      if (AW < 9 || AW > 16) begin : g_bad_aw
         $error("AW must lie in 9..16");
      end
      if ((1 << AW) < BUF_BYTES) begin : g_bad_buf
         $error("AW too narrow for BUF_BYTES");
      end
   endgenerate

   logic [IW-1:0] tok_idx, lk_idx, wb_idx;
   logic          tok_hit, wb_en, wb_cnt_we, wb_cnt_half;
   logic [7:0]    lk_ctl, lk_size, lk_cnt0, lk_cnt1, wb_ctl, wb_cnt;
   logic [AW-1:0] lk_base;
   logic [6:0]    dev_addr;

   ebm_desc_file #(.NDESC(NDESC), .IW(IW), .AW(AW)) i_desc (
      .clk(clk), .rst_n(rst_n),
      .cpu_we(cfg_we), .cpu_idx(cfg_idx), .cpu_byte(cfg_byte),
      .cpu_wdata(cfg_wdata), .cpu_rdata(cfg_rdata),
      .lk_idx(lk_idx), .lk_ctl(lk_ctl), .lk_base(lk_base), .lk_size(lk_size),
      .lk_cnt0(lk_cnt0), .lk_cnt1(lk_cnt1), .dev_addr(dev_addr),
      .wb_en(wb_en), .wb_idx(wb_idx), .wb_ctl(wb_ctl), .wb_cnt_we(wb_cnt_we),
      .wb_cnt_half(wb_cnt_half), .wb_cnt(wb_cnt)
   );

   ebm_tok_decode #(.NUM_EP(NUM_EP), .IW(IW)) i_dec (
      .tok_addr(tok_addr), .tok_ep(tok_ep), .tok_in(tok_in),
      .dev_addr(dev_addr), .hit(tok_hit), .idx(tok_idx)
   );

   ebm_xfer #(.IW(IW), .AW(AW), .DBL_EN(DBL_EN)) i_xfer (
      .clk(clk), .rst_n(rst_n),
      .tok_valid(tok_valid), .tok_hit(tok_hit), .tok_in(tok_in), .tok_idx(tok_idx),
      .lk_idx(lk_idx), .lk_ctl(lk_ctl), .lk_base(lk_base), .lk_size(lk_size),
      .lk_cnt0(lk_cnt0), .lk_cnt1(lk_cnt1),
      .resp_ack(resp_ack), .resp_nak(resp_nak),
      .rx_valid(rx_valid), .rx_data(rx_data), .rx_end(rx_end),
      .tx_req(tx_req), .tx_len(tx_len), .tx_valid(tx_valid), .tx_data(tx_data),
      .tx_last(tx_last),
      .ram_we(ram_we), .ram_re(ram_re), .ram_addr(ram_addr),
      .ram_wdata(ram_wdata), .ram_rdata(ram_rdata),
      .wb_en(wb_en), .wb_idx(wb_idx), .wb_ctl(wb_ctl), .wb_cnt_we(wb_cnt_we),
      .wb_cnt_half(wb_cnt_half), .wb_cnt(wb_cnt)
   );

   // R1
   addr_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (resp_ack || resp_nak) |-> ($past(tok_addr) == $past(dev_addr)));
endmodule

// File: tb/test_usb_ep_bufmgr.sv
module test_usb_ep_bufmgr;
   localparam int CLK_PERIOD = 10;
   localparam logic [6:0] DEV = 7'h2A;

   logic clk = 1'b0, rst_n = 1'b0;
   logic cfg_we = 0; logic [3:0] cfg_idx = 0; logic [2:0] cfg_byte = 0;
   logic [7:0] cfg_wdata = 0, cfg_rdata;
   logic tok_valid = 0; logic [6:0] tok_addr = 0; logic [3:0] tok_ep = 0; logic tok_in = 0;
   logic resp_ack, resp_nak;
   logic rx_valid = 0, rx_end = 0, tx_req = 0; logic [7:0] rx_data = 0;
   logic [7:0] tx_len, tx_data; logic tx_valid, tx_last;
   logic ram_we, ram_re; logic [10:0] ram_addr; logic [7:0] ram_wdata;
   logic [7:0] ram_rdata = 0;
   logic tb_we = 0; logic [10:0] tb_addr = 0; logic [7:0] tb_data = 0;
   logic [7:0] mem [2048];
   int n_tests = 0, n_fail = 0, we_cnt = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   usb_ep_bufmgr i_usb_ep_bufmgr (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
      .cfg_byte(cfg_byte), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
      .tok_valid(tok_valid), .tok_addr(tok_addr), .tok_ep(tok_ep), .tok_in(tok_in),
      .resp_ack(resp_ack), .resp_nak(resp_nak), .rx_valid(rx_valid),
      .rx_data(rx_data), .rx_end(rx_end), .tx_req(tx_req), .tx_len(tx_len),
      .tx_valid(tx_valid), .tx_data(tx_data), .tx_last(tx_last),
      .ram_we(ram_we), .ram_re(ram_re), .ram_addr(ram_addr),
      .ram_wdata(ram_wdata), .ram_rdata(ram_rdata)
   );

   always @(posedge clk) begin
      if (ram_we) begin mem[ram_addr] <= ram_wdata; we_cnt <= we_cnt + 1; end
      else if (tb_we) mem[tb_addr] <= tb_data;
      if (ram_re) ram_rdata <= mem[ram_addr];
   end

   task automatic chk(input string req, input int act, input int exp);
      n_tests++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic cfg_wr(input int idx, input int b, input int d);
      @(negedge clk); cfg_we = 1; cfg_idx = 4'(idx); cfg_byte = 3'(b); cfg_wdata = 8'(d);
      @(negedge clk); cfg_we = 0;
   endtask

   task automatic cfg_rd(input int idx, input int b, output int d);
      @(negedge clk); cfg_idx = 4'(idx); cfg_byte = 3'(b);
      #1 d = int'(cfg_rdata);
   endtask

   task automatic set_desc(input int idx, input int ctl, input int base,
                           input int size, input int c0, input int c1);
      cfg_wr(idx, 0, ctl); cfg_wr(idx, 1, base & 255); cfg_wr(idx, 2, base >> 8);
      cfg_wr(idx, 3, size); cfg_wr(idx, 4, c0); cfg_wr(idx, 5, c1);
   endtask

   task automatic ram_put(input int a, input int d);
      @(negedge clk); tb_we = 1; tb_addr = 11'(a); tb_data = 8'(d);
      @(negedge clk); tb_we = 0;
   endtask

   task automatic token(input int a, input int ep, input bit din,
                        output int ack, output int nak);
      @(negedge clk); tok_valid = 1; tok_addr = 7'(a); tok_ep = 4'(ep); tok_in = din;
      @(negedge clk); tok_valid = 0; ack = int'(resp_ack); nak = int'(resp_nak);
   endtask

   task automatic send_out(input int n, input int seed);
      for (int i = 0; i < n; i++) begin
         @(negedge clk); rx_valid = 1; rx_data = 8'(seed + i);
      end
      @(negedge clk); rx_valid = 0; rx_end = 1;
      @(negedge clk); rx_end = 0;
   endtask

   task automatic recv_in(input string req, input int n, input int a0);
      for (int i = 0; i < n; i++) begin
         @(negedge clk); tx_req = 1;
         @(negedge clk); tx_req = 0;
         chk({req, " tx_valid"}, int'(tx_valid), 1);
         chk({req, " tx_data"}, int'(tx_data), int'(mem[a0 + i]));
         chk({req, " tx_last"}, int'(tx_last), (i == n - 1) ? 1 : 0);
      end
   endtask

   task automatic finish_up;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_tests++; n_fail++;
      $display("FAIL watchdog expired");
      finish_up();
   end

   initial begin
      int ack, nak, d, base, seed, n, w0;
      for (int i = 0; i < 2048; i++) mem[i] = 8'h00;
      repeat (3) @(negedge clk);
      rst_n = 1;
      // reset state
      cfg_rd(1, 0, d);
      chk("R3 reset desc", d, 0);
      chk("R4 reset ack", int'(resp_ack), 0);
      chk("R4 reset nak", int'(resp_nak), 0);

      // R3: full descriptor write/readback sweep
      for (int s = 0; s < 16; s++)
         for (int b = 0; b < 6; b++) cfg_wr(s, b, (s*7 + b*13 + 1) & 255);
      for (int s = 0; s < 16; s++) begin
         for (int b = 0; b < 8; b++) begin
            cfg_rd(s, b, d);
            chk("R3 readback", d, (b < 6) ? ((s*7 + b*13 + 1) & 255) : 0);
         end
      end
      for (int s = 0; s < 15; s++) set_desc(s, 0, 0, 0, 0, 0);
      cfg_wr(15, 0, DEV);

      // R1/R4: address sweep against a disabled endpoint
      for (int a = 0; a < 128; a++) begin
         token(a, 1, 1'b1, ack, nak);
         chk("R1 addr sweep nak", nak, (a == DEV) ? 1 : 0);
         chk("R1 addr sweep ack", ack, 0);
      end
      for (int ep = 8; ep < 16; ep++) begin
         token(DEV, ep, 1'b0, ack, nak);
         chk("R1 ep out of range", ack + nak, 0);
      end

      // R2/R5/R7/R12: OUT on every endpoint, single buffered
      for (int ep = 0; ep < 8; ep++) begin
         int idx;
         idx = (ep == 0) ? 0 : ep + 7;
         base = ep*64 + 3; seed = ep*16 + 'h40; n = ep + 2;
         set_desc(idx, 'h80, base, 16, 0, 0);
         token(DEV, ep, 1'b0, ack, nak);
         chk("R4 OUT ack", ack, 1);
         send_out(n, seed);
         for (int i = 0; i < n; i++) chk("R5 OUT data", int'(mem[base + i]), (seed + i) & 255);
         cfg_rd(idx, 4, d); chk("R7 OUT count", d, n);
         cfg_rd(idx, 0, d); chk("R12 OUT ctl single", d, 'h84);
         if (ep != 0) begin
            token(DEV, ep, 1'b1, ack, nak);
            chk("R2 IN slot separate", nak, 1);
         end
      end
      // R2: control endpoint shares slot 0, IN reads back the OUT data
      token(DEV, 0, 1'b1, ack, nak);
      chk("R2 ctrl IN ack", ack, 1);
      chk("R9 ctrl tx_len", int'(tx_len), 2);
      recv_in("R2 ctrl IN", 2, 3);

      // R8: OUT to full half refused, data ignored
      w0 = we_cnt;
      token(DEV, 3, 1'b0, ack, nak);
      chk("R8 full nak", nak, 1);
      send_out(3, 'h99);
      chk("R8 no writes", we_cnt, w0);
      cfg_rd(10, 4, d); chk("R8 count kept", d, 5);

      // R6: overflow truncation
      ram_put(1004, 'hEE);
      set_desc(12, 'h80, 1000, 4, 0, 0);
      token(DEV, 5, 1'b0, ack, nak);
      chk("R6 ack", ack, 1);
      send_out(7, 'h10);
      for (int i = 0; i < 4; i++) chk("R6 data", int'(mem[1000 + i]), 'h10 + i);
      chk("R6 beyond untouched", int'(mem[1004]), 'hEE);
      cfg_rd(12, 4, d); chk("R6 count", d, 4);
      cfg_rd(12, 0, d); chk("R6 ovf ctl", d, 'hA4);

      // R7: double buffered OUT
      set_desc(13, 'hC0, 1200, 8, 0, 0);
      token(DEV, 6, 1'b0, ack, nak); chk("R7 dbl ack A", ack, 1);
      send_out(3, 'h20);
      cfg_rd(13, 0, d); chk("R7 dbl ctl A", d, 'hD4);
      cfg_rd(13, 4, d); chk("R7 dbl cnt0", d, 3);
      token(DEV, 6, 1'b0, ack, nak); chk("R7 dbl ack B", ack, 1);
      send_out(5, 'h30);
      for (int i = 0; i < 5; i++) chk("R5 half1 data", int'(mem[1208 + i]), 'h30 + i);
      cfg_rd(13, 0, d); chk("R7 dbl ctl B", d, 'hCC);
      cfg_rd(13, 5, d); chk("R7 dbl cnt1", d, 5);
      token(DEV, 6, 1'b0, ack, nak); chk("R8 dbl both full nak", nak, 1);

      // R9/R10: single buffered IN
      for (int i = 0; i < 5; i++) ram_put(1400 + i, 'hA0 + i*3);
      set_desc(2, 'h84, 1400, 8, 5, 0);
      token(DEV, 2, 1'b1, ack, nak);
      chk("R9 IN ack", ack, 1);
      chk("R9 IN tx_len", int'(tx_len), 5);
      recv_in("R9 IN", 5, 1400);
      cfg_rd(2, 0, d); chk("R10 IN full cleared", d, 'h80);
      token(DEV, 2, 1'b1, ack, nak); chk("R10 IN empty nak", nak, 1);

      // R10: double buffered IN
      for (int i = 0; i < 8; i++) ram_put(1500 + i, 'h51 + i*5);
      set_desc(4, 'hCC, 1500, 4, 2, 3);
      token(DEV, 4, 1'b1, ack, nak);
      chk("R9 dbl IN len0", int'(tx_len), 2);
      recv_in("R9 dbl IN h0", 2, 1500);
      cfg_rd(4, 0, d); chk("R10 dbl ctl h0", d, 'hD8);
      token(DEV, 4, 1'b1, ack, nak);
      chk("R9 dbl IN len1", int'(tx_len), 3);
      recv_in("R9 dbl IN h1", 3, 1504);
      cfg_rd(4, 0, d); chk("R10 dbl ctl h1", d, 'hC0);
      token(DEV, 4, 1'b1, ack, nak); chk("R10 dbl empty nak", nak, 1);

      // R11: zero-length IN
      set_desc(7, 'h84, 1600, 8, 0, 0);
      token(DEV, 7, 1'b1, ack, nak);
      chk("R11 zlp ack", ack, 1);
      chk("R11 zlp len", int'(tx_len), 0);
      chk("R11 zlp no byte", int'(tx_valid), 0);
      cfg_rd(7, 0, d); chk("R11 zlp ctl", d, 'h80);

      finish_up();
   end
endmodule